// File: doc/BRIEF.md
# Floating-Point Exponent and Shift Datapath

This block is the exponent half of a double-precision floating-point unit. A sequencing controller drives a flat set of select, negate and enable controls every cycle. The block turns them into two registered quantities: the working result exponent and the mantissa shift count. Each quantity comes from its own two-input adder. Each adder input is picked by a multiplexer from operand exponents, the current register state or a small table of constants, and either input may be two's-complement negated.

The shift path has one extra input. A leading-zero count of the mantissa is registered on arrival and can be loaded straight into the shift register. That path bypasses the adder, so the count does not add an adder's delay to the timing path. A helper value, the current result exponent minus the current shift, is formed from the two registers and can feed either adder. All values are signed two's-complement numbers `EXP_W` bits wide, 13 by default. Sums wrap modulo 2^EXP_W.

Top module: `fp_expo_path`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released, `res_exp` and `shift` read 0. The registered leading-zero count also resets to 0.
- R2: On each clock edge with `re_set`=1, `res_exp` takes X1 + X2 mod 2^13. X1 is operand 1, negated when `re_neg1`=1. X2 is operand 2, negated when `re_neg2`=1.
- R3: `re_sel1` picks result operand 1. The codes are 0 = current `res_exp`, 1 = `a_exp`, 2 = `b_exp` arithmetically shifted right by one bit, and 3 = zero.
- R4: `re_sel2` picks result operand 2. The codes are 0 = `res_exp - shift` (both current register values), 1 = `b_exp`, 2 = `c_exp`, and 3 = a constant. `re_const` selects the constant: 0 = 0, 1 = 56, 2 = 1023 (maximum exponent), 3 = 1536 (overflow bias adjustment).
- R5: On each clock edge with `sh_set`=1 and `sh_lzc`=0, `shift` takes Y1 + Y2 mod 2^13, with the same negation rule as R2 using `sh_neg1` and `sh_neg2`. `sh_sel1` picks Y1: 0 = `res_exp - shift`, 1 = `b_exp`, 2 = current `shift`, 3 = zero.
- R6: `sh_sel2` picks Y2: 0 = `a_exp`, 1 = a constant. `sh_const` selects the constant: 0→0, 1→1, 2→4, 3→8, 4→32, 5→52, 6→56, 7→63, 8→64, 9→-1022 (minimum exponent). Codes 10 to 15 give 0.
- R7: `lzc_in` is registered on every edge. On an edge with `sh_set`=1 and `sh_lzc`=1, `shift` takes the zero-extended registered count, which is the `lzc_in` value present one edge earlier. A zero mantissa (count 64) therefore loads 64.
- R8: `re_set` and `sh_set` are independent. A register whose enable is 0 keeps its value across the edge.
- R9: The controller never asserts both negate flags of the same adder in one cycle.
- R10: Arithmetic wraps in 13-bit two's complement. For example, 4095 + 1023 stores -3074.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_exp | input | 13 | Exponent of operand A |
| b_exp | input | 13 | Exponent of operand B |
| c_exp | input | 13 | Exponent of operand C |
| lzc_in | input | 7 | Leading-zero count of the mantissa (0 to 64) |
| re_sel1 | input | 2 | Result adder operand 1 select |
| re_neg1 | input | 1 | Negate result operand 1 |
| re_sel2 | input | 2 | Result adder operand 2 select |
| re_neg2 | input | 1 | Negate result operand 2 |
| re_const | input | 2 | Result constant code |
| re_set | input | 1 | Write enable for `res_exp` |
| sh_sel1 | input | 2 | Shift adder operand 1 select |
| sh_neg1 | input | 1 | Negate shift operand 1 |
| sh_sel2 | input | 1 | Shift adder operand 2 select |
| sh_neg2 | input | 1 | Negate shift operand 2 |
| sh_const | input | 4 | Shift constant code |
| sh_lzc | input | 1 | Load shift from the registered leading-zero count |
| sh_set | input | 1 | Write enable for `shift` |
| res_exp | output | 13 | Registered result exponent |
| shift | output | 13 | Registered shift count |

## Verification
The embedded checks rely on two promises from the controller. The first is that the two negate flags of an adder are never high together. The second is that the leading-zero count never exceeds the mantissa width. The stimulus generator draws both negate flags from a three-valued choice that excludes the pair. It draws the count only from 0 to 64. Directed sequences walk every constant code, including the unused shift codes. They also cover a zero mantissa and deliberate wraparound. The random phase keeps the same two promises.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   typedef enum logic [1:0] {
      RE1_RES   = 2'd0,
      RE1_AEXP  = 2'd1,
      RE1_BHALF = 2'd2,
      RE1_ZERO  = 2'd3
   } re_op1_e;

   typedef enum logic [1:0] {
      RE2_DIFF  = 2'd0,
      RE2_BEXP  = 2'd1,
      RE2_CEXP  = 2'd2,
      RE2_CONST = 2'd3
   } re_op2_e;

   typedef enum logic [1:0] {
      SH1_DIFF  = 2'd0,
      SH1_BEXP  = 2'd1,
      SH1_SHIFT = 2'd2,
      SH1_ZERO  = 2'd3
   } sh_op1_e;

   localparam int TBL_RESULT = 0;
   localparam int TBL_SHIFT  = 1;
endpackage

// File: rtl/fpx_mux4.sv
module fpx_mux4 #(
   parameter int W = 13
) (
   input  logic [1:0]   sel,
   input  logic [W-1:0] d0,
   input  logic [W-1:0] d1,
   input  logic [W-1:0] d2,
   input  logic [W-1:0] d3,
   output logic [W-1:0] y
);
   always_comb begin
      unique case (sel)
         2'd0:    y = d0;
         2'd1:    y = d1;
         2'd2:    y = d2;
         default: y = d3;
      endcase
   end
endmodule

// File: rtl/fpx_const_table.sv
module fpx_const_table #(
   parameter int W       = 13,
   parameter int PATH    = 0,
   parameter int MAX_EXP = 1023,
   parameter int MIN_EXP = -1022,
   parameter int OVF_ADJ = 1536
) (
   input  logic [3:0]   code,
   output logic [W-1:0] value
);
   import fpx_pkg::*;

   generate
      if (PATH == TBL_RESULT) begin : g_result
         always_comb begin
            unique case (code[1:0])
               2'd0:    value = W'(0);
               2'd1:    value = W'(56);
               2'd2:    value = W'(MAX_EXP);
               default: value = W'(OVF_ADJ);
            endcase
         end
      end else begin : g_shift
         always_comb begin
            case (code)
               4'd0:    value = W'(0);
               4'd1:    value = W'(1);
               4'd2:    value = W'(4);
               4'd3:    value = W'(8);
               4'd4:    value = W'(32);
               4'd5:    value = W'(52);
               4'd6:    value = W'(56);
               4'd7:    value = W'(63);
               4'd8:    value = W'(64);
               4'd9:    value = W'(MIN_EXP);
               default: value = W'(0);
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/fpx_neg_add.sv
module fpx_neg_add #(
   parameter int W        = 13,
   parameter int NEG_IMPL = 0
) (
   input  logic [W-1:0] x,
   input  logic         neg_x,
   input  logic [W-1:0] z,
   input  logic         neg_z,
   output logic [W-1:0] sum
);
   generate
      if (NEG_IMPL == 0) begin : g_explicit
         logic [W-1:0] xo, zo;
         assign xo  = neg_x ? (~x + W'(1)) : x;
         assign zo  = neg_z ? (~z + W'(1)) : z;
         assign sum = xo + zo;
      end else begin : g_carry_in
         logic [W-1:0] xi, zi;
         assign xi  = x ^ {W{neg_x}};
         assign zi  = z ^ {W{neg_z}};
         assign sum = xi + zi + W'(neg_x) + W'(neg_z);
      end
   endgenerate
endmodule

// File: rtl/fp_expo_path.sv
module fp_expo_path #(
   parameter int EXP_W      = 13,
   parameter int MANT_W     = 64,
   parameter int MAX_EXP    = 1023,
   parameter int MIN_EXP    = -1022,
   parameter int OVF_ADJ    = 1536,
   parameter int NEG_IMPL   = 0,
   parameter bit LZC_STAGE  = 1'b1,
   localparam int LZC_W     = $clog2(MANT_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EXP_W-1:0] a_exp,
   input  logic [EXP_W-1:0] b_exp,
   input  logic [EXP_W-1:0] c_exp,
   input  logic [LZC_W-1:0] lzc_in,
   input  logic [1:0]       re_sel1,
   input  logic             re_neg1,
   input  logic [1:0]       re_sel2,
   input  logic             re_neg2,
   input  logic [1:0]       re_const,
   input  logic             re_set,
   input  logic [1:0]       sh_sel1,
   input  logic             sh_neg1,
   input  logic             sh_sel2,
   input  logic             sh_neg2,
   input  logic [3:0]       sh_const,
   input  logic             sh_lzc,
   input  logic             sh_set,
   output logic [EXP_W-1:0] res_exp,
   output logic [EXP_W-1:0] shift
);
   import fpx_pkg::*;

   localparam int SPAN = 1 << (EXP_W - 1);

   generate
      if (EXP_W < 8 || EXP_W > 32) begin : g_bad_width
         $error("fp_expo_path: EXP_W out of range");
      end
      if (MAX_EXP >= SPAN || OVF_ADJ >= SPAN || -MIN_EXP > SPAN) begin : g_bad_const
         $error("fp_expo_path: constants do not fit EXP_W");
      end
      if (LZC_W >= EXP_W) begin : g_bad_lzc
         $error("fp_expo_path: count width too wide");
      end
   endgenerate

   logic [LZC_W-1:0] lzc_q;
   generate
      if (LZC_STAGE) begin : g_lzc_reg
         always_ff @(posedge clk) begin
            if (!rst_n) lzc_q <= '0;
            else        lzc_q <= lzc_in;
         end
      end else begin : g_lzc_wire
         assign lzc_q = lzc_in;
      end
   endgenerate

   logic [EXP_W-1:0] diff_exp, b_half, re_k, sh_k;
   logic [EXP_W-1:0] re_x, re_z, sh_x, sh_z, re_sum, sh_sum, sh_next;

   assign diff_exp = res_exp - shift;
   assign b_half   = {b_exp[EXP_W-1], b_exp[EXP_W-1:1]};

   fpx_const_table #(.W(EXP_W), .PATH(TBL_RESULT), .MAX_EXP(MAX_EXP),
                     .MIN_EXP(MIN_EXP), .OVF_ADJ(OVF_ADJ)) u_re_tbl (
      .code ({2'b00, re_const}), .value(re_k));

   fpx_const_table #(.W(EXP_W), .PATH(TBL_SHIFT), .MAX_EXP(MAX_EXP),
                     .MIN_EXP(MIN_EXP), .OVF_ADJ(OVF_ADJ)) u_sh_tbl (
      .code (sh_const), .value(sh_k));

   fpx_mux4 #(.W(EXP_W)) u_re_m1 (.sel(re_sel1),
      .d0(res_exp), .d1(a_exp), .d2(b_half), .d3('0), .y(re_x));

   fpx_mux4 #(.W(EXP_W)) u_re_m2 (.sel(re_sel2),
      .d0(diff_exp), .d1(b_exp), .d2(c_exp), .d3(re_k), .y(re_z));

   fpx_mux4 #(.W(EXP_W)) u_sh_m1 (.sel(sh_sel1),
      .d0(diff_exp), .d1(b_exp), .d2(shift), .d3('0), .y(sh_x));

   assign sh_z = sh_sel2 ? sh_k : a_exp;

   fpx_neg_add #(.W(EXP_W), .NEG_IMPL(NEG_IMPL)) u_re_add (
      .x(re_x), .neg_x(re_neg1), .z(re_z), .neg_z(re_neg2), .sum(re_sum));

   fpx_neg_add #(.W(EXP_W), .NEG_IMPL(NEG_IMPL)) u_sh_add (
      .x(sh_x), .neg_x(sh_neg1), .z(sh_z), .neg_z(sh_neg2), .sum(sh_sum));

   // normalization count joins after the adder
   assign sh_next = sh_lzc ? {{(EXP_W-LZC_W){1'b0}}, lzc_q} : sh_sum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_exp <= '0;
         shift   <= '0;
      end else begin
         if (re_set) res_exp <= re_sum;
         if (sh_set) shift   <= sh_next;
      end
   end

   assert_one_neg_re_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(re_neg1 && re_neg2));
   assert_one_neg_sh_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(sh_neg1 && sh_neg2));
   assert_lzc_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lzc_in <= LZC_W'(MANT_W));
   assert_hold_res_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !re_set |=> $stable(res_exp));
   assert_hold_sh_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_set |=> $stable(shift));
   assert_zero_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (re_set && re_sel1 == RE1_ZERO && re_sel2 == RE2_CONST && re_const == 2'd0)
      |=> res_exp == '0);
   generate
      if (LZC_STAGE) begin : g_lzc_chk
         assert_lzc_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (sh_set && sh_lzc && $past(rst_n)) |=> shift[LZC_W-1:0] == $past(lzc_in, 2));
      end
   endgenerate
endmodule

// File: tb/fp_expo_path_tb.sv
module fp_expo_path_tb;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n;
   logic [12:0] a_exp, b_exp, c_exp;
   logic [6:0]  lzc_in;
   logic [1:0]  re_sel1, re_sel2, re_const, sh_sel1;
   logic        re_neg1, re_neg2, re_set, sh_neg1, sh_sel2, sh_neg2, sh_lzc, sh_set;
   logic [3:0]  sh_const;
   logic [12:0] res_exp, shift;

   fp_expo_path u_dut (.*);

   int n_chk = 0, n_bad = 0;
   int m_res = 0, m_sh = 0, m_lzc = 0;
   bit done = 0;

   function automatic int sx(logic [12:0] v);
      return v[12] ? int'(v) - 8192 : int'(v);
   endfunction

   function automatic int wrap(int v);
      return sx(13'(v));
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int sh_table(int code);
      case (code)
         0: return 0;  1: return 1;  2: return 4;  3: return 8;
         4: return 32; 5: return 52; 6: return 56; 7: return 63;
         8: return 64; 9: return -1022;
         default: return 0;
      endcase
   endfunction

   // reference: next state from current model state and applied inputs
   task automatic model_next();
      int x1, x2, y1, y2, diff;
      int re_k [4] = '{0, 56, 1023, 1536};
      diff = m_res - m_sh;
      case (re_sel1)
         0: x1 = m_res; 1: x1 = sx(a_exp); 2: x1 = sx(b_exp) >>> 1; default: x1 = 0;
      endcase
      case (re_sel2)
         0: x2 = diff; 1: x2 = sx(b_exp); 2: x2 = sx(c_exp); default: x2 = re_k[re_const];
      endcase
      case (sh_sel1)
         0: y1 = diff; 1: y1 = sx(b_exp); 2: y1 = m_sh; default: y1 = 0;
      endcase
      y2 = sh_sel2 ? sh_table(int'(sh_const)) : sx(a_exp);
      if (re_neg1) x1 = -x1;
      if (re_neg2) x2 = -x2;
      if (sh_neg1) y1 = -y1;
      if (sh_neg2) y2 = -y2;
      if (sh_set) m_sh = sh_lzc ? m_lzc : wrap(y1 + y2);
      if (re_set) m_res = wrap(x1 + x2);
      m_lzc = int'(lzc_in);
   endtask

   task automatic step(string tag);
      model_next();
      @(posedge clk);
      @(negedge clk);
      check(tag, "res_exp", sx(res_exp), m_res);
      check(tag, "shift", sx(shift), m_sh);
   endtask

   task automatic idle();
      re_set = 0; sh_set = 0; sh_lzc = 0;
      re_neg1 = 0; re_neg2 = 0; sh_neg1 = 0; sh_neg2 = 0;
      re_sel1 = 0; re_sel2 = 0; re_const = 0; sh_sel1 = 0; sh_sel2 = 0; sh_const = 0;
   endtask

   task automatic rand_ctrl();
      int n;
      a_exp = 13'($urandom); b_exp = 13'($urandom); c_exp = 13'($urandom);
      lzc_in = 7'($urandom_range(0, 64));
      re_sel1 = 2'($urandom); re_sel2 = 2'($urandom); re_const = 2'($urandom);
      sh_sel1 = 2'($urandom); sh_sel2 = 1'($urandom); sh_const = 4'($urandom);
      n = $urandom_range(0, 2); re_neg1 = (n == 1); re_neg2 = (n == 2);  // R9
      n = $urandom_range(0, 2); sh_neg1 = (n == 1); sh_neg2 = (n == 2);
      re_set = 1'($urandom); sh_set = 1'($urandom); sh_lzc = ($urandom_range(0, 3) == 0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 0; idle();
      a_exp = 0; b_exp = 0; c_exp = 0; lzc_in = 0;
      repeat (3) @(negedge clk);
      check("R1", "res_exp in reset", sx(res_exp), 0);
      check("R1", "shift in reset", sx(shift), 0);
      rst_n = 1;
      step("R1");

      // R3: each first-operand source, operand 2 = constant 0
      a_exp = 13'(300); b_exp = 13'(-301); c_exp = 13'(77);
      for (int s = 0; s < 4; s++) begin
         idle(); re_set = 1; re_sel1 = 2'(s); re_sel2 = 2'd3;
         step("R3");
      end
      // R4: every constant and the other sources
      for (int k = 0; k < 4; k++) begin
         idle(); re_set = 1; re_sel1 = 2'd3; re_sel2 = 2'd3; re_const = 2'(k);
         step("R4");
      end
      for (int s = 0; s < 3; s++) begin
         idle(); re_set = 1; re_sel1 = 2'd1; re_sel2 = 2'(s); re_neg2 = 1;
         step("R4");
      end
      // R6: every shift constant code, including unused ones
      for (int k = 0; k < 16; k++) begin
         idle(); sh_set = 1; sh_sel1 = 2'd3; sh_sel2 = 1; sh_const = 4'(k);
         step("R6");
      end
      // R5: shift first-operand sources with A as operand 2
      for (int s = 0; s < 4; s++) begin
         idle(); sh_set = 1; sh_sel1 = 2'(s); sh_sel2 = 0; sh_neg1 = (s == 1);
         step("R5");
      end
      // R7: zero mantissa count 64, then a normal count
      idle(); lzc_in = 7'd64; step("R7");
      lzc_in = 7'd5; sh_set = 1; sh_lzc = 1; step("R7");
      lzc_in = 7'd0; step("R7");
      // R8: no enables, inputs busy
      idle(); a_exp = 13'(999); re_sel1 = 2'd1; sh_sel2 = 0; lzc_in = 7'd33;
      step("R8"); step("R8");
      // R2 and R10: wraparound
      idle(); re_set = 1; a_exp = 13'(4095); re_sel1 = 2'd1; re_sel2 = 2'd3; re_const = 2'd2;
      step("R10");
      check("R10", "wrapped res_exp", sx(res_exp), -3074);
      idle(); re_set = 1; re_sel1 = 2'd0; re_sel2 = 2'd3; re_const = 2'd3; re_neg1 = 1;
      step("R2");

      for (int i = 0; i < 3000; i++) begin
         rand_ctrl();
         step(re_set ? "R2" : "R8");
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule